// File: doc/BRIEF.md
# SPI Flash Opcode Command Engine

This block lets software send one serial-flash instruction at a time over a single-lane SPI master port. Software writes an 8-bit instruction code into a control word, along with a direction flag and a payload length of up to eight bytes. Outgoing payload bytes are held in two 32-bit data words. Writing the control word with its launch bit set starts the transfer. The engine then frames the transfer with chip select, clocks out the instruction and any payload, and collects the bytes that return into two readable 32-bit result words.

Five common flash operations have shortcut registers. Writing one of them builds the instruction directly: write-enable, status-register write, status-register read, 64 KB sector erase with a four-byte address, and a four-byte identification read. Every launch attempt produces an 11-bit result code. A failed attempt also sets an error flag that stays set until reset. A level interrupt combines that error flag with a "returned data ready" flag, and each source can be masked.

The register port writes in one cycle and reads with one cycle of latency. The SPI clock half-period is `CLK_DIV` system clocks.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 0 and `irq` is 0. Reads return: result code (address 0) = 0, flag word (address 1) = 0, mask word (address 2) = 3.
- R2: Transfers use SPI mode 0. Chip select is low for the whole transfer and SCLK stays low while chip select is high. MOSI changes only on SCLK falling edges and is sampled by the device on rising edges. Every byte goes out MSB first, and the instruction byte comes first.
- R3: Control word (address 8) = {code[31:24], 17'b0, rd[6], wr[5], 4'b0, go[0]}. When wr=1, the length field (address 9, bits 3:0) gives N bytes. These are sent after the instruction, taken from payload lane k = bits 8k+7:8k of {hi word (address 11), lo word (address 10)} for k = 0..N-1.
- R4: When rd=1, N bytes are clocked in after the instruction while MOSI sends 0x00. Returned byte k goes to lane k of {result hi (address 13), result lo (address 12)}, and unused lanes read 0. If N ≥ 1, flag bit 1 (data ready) is set at completion. The next accepted launch clears it.
- R5: Reading the control word returns the stored code and flags. Bit 0 (the launch bit) always reads 0.
- R6: A launch with a length above 8 is rejected with result code 1, and no transfer takes place.
- R7: A nonzero length with neither flag set is rejected with code 2. A zero length with neither flag set sends only the instruction byte and gives code 0.
- R8: A launch with both rd and wr set is rejected with code 4.
- R9: A launch attempt while a transfer is running is ignored and sets code 3. The running transfer finishes unchanged. An accepted launch sets code 0.
- R10: Flag bit 0 (error) is set by every rejected attempt, whether for codes 1–4. Only reset clears it, so later successful commands leave it set.
- R11: `irq` is a register equal to (error & mask bit 0) | (data ready & mask bit 1), following the flags one cycle later.
- R12: The shortcut registers work as follows. Address 3 with bit 0 = 1 sends 0x06 alone. Address 4 sends 0x01 followed by bits 7:0 of the written value. Address 5 sends 0x05 and reads one byte, which is then readable at address 5 in bits 7:0.
- R13: Address 6 sends 0xD8 followed by the written 32-bit address, most significant byte first. Address 7 sends 0x9F and reads four bytes, readable at address 7 with the first returned byte in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | ADDR_W | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | ADDR_W | Register read address |
| reg_rdata | output | 32 | Registered read data, one cycle after the address |
| irq | output | 1 | Masked interrupt |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The hardest case to reach is a launch attempt that arrives while a transfer is in progress. It must be rejected without disturbing the bytes already being shifted. To create it, the stimulus starts an eight-byte write, issues a second launch a few cycles later, and then checks that exactly one frame with the original payload reached the bench's flash model. Returned data is checked with a model that drives MISO from a pattern seeded per command. Random lengths and instruction codes cover every lane boundary, and directed cases cover lengths 0, 8, 9 and 15.

// File: rtl/fce_pkg.sv
package fce_pkg;
  localparam int FCE_NB = 8;

  localparam int A_RESP  = 0;
  localparam int A_FLAGS = 1;
  localparam int A_MASK  = 2;
  localparam int A_WREN  = 3;
  localparam int A_STWR  = 4;
  localparam int A_STRD  = 5;
  localparam int A_ERASE = 6;
  localparam int A_IDENT = 7;
  localparam int A_CTRL  = 8;
  localparam int A_LEN   = 9;
  localparam int A_WLO   = 10;
  localparam int A_WHI   = 11;
  localparam int A_RLO   = 12;
  localparam int A_RHI   = 13;

  localparam logic [10:0] RC_OK     = 11'd0;
  localparam logic [10:0] RC_BADLEN = 11'd1;
  localparam logic [10:0] RC_NODIR  = 11'd2;
  localparam logic [10:0] RC_BUSY   = 11'd3;
  localparam logic [10:0] RC_BOTH   = 11'd4;

  typedef struct packed {
    logic [7:0]          op;
    logic [8*FCE_NB-1:0] tx;
    logic [3:0]          ntx;
    logic [3:0]          nrx;
  } fce_cmd_t;
endpackage

// File: rtl/fce_cmd_build.sv
module fce_cmd_build
  import fce_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                  we,
  input  logic [ADDR_W-1:0]     waddr,
  input  logic [31:0]           wdata,
  input  logic [3:0]            len,
  input  logic [8*FCE_NB-1:0]   payload,
  output logic                  launch,
  output fce_cmd_t              cmd,
  output logic [10:0]           code
);
  logic rd_f, wr_f;
  assign rd_f = wdata[6];
  assign wr_f = wdata[5];

  always_comb begin
    launch = 1'b0;
    code   = RC_OK;
    cmd    = '0;
    if (waddr == ADDR_W'(A_WREN)) begin
      launch = wdata[0];
      cmd.op = 8'h06;
    end else if (waddr == ADDR_W'(A_STWR)) begin
      launch = 1'b1;
      cmd.op = 8'h01;
      cmd.tx[7:0] = wdata[7:0];
      cmd.ntx = 4'd1;
    end else if (waddr == ADDR_W'(A_STRD)) begin
      launch = 1'b1;
      cmd.op = 8'h05;
      cmd.nrx = 4'd1;
    end else if (waddr == ADDR_W'(A_ERASE)) begin
      launch = 1'b1;
      cmd.op = 8'hD8;
      cmd.tx[31:0] = {wdata[7:0], wdata[15:8], wdata[23:16], wdata[31:24]};
      cmd.ntx = 4'd4;
    end else if (waddr == ADDR_W'(A_IDENT)) begin
      launch = 1'b1;
      cmd.op = 8'h9F;
      cmd.nrx = 4'd4;
    end else if (waddr == ADDR_W'(A_CTRL)) begin
      launch = wdata[0];
      cmd.op = wdata[31:24];
      cmd.tx = payload;
      cmd.ntx = wr_f ? len : 4'd0;
      cmd.nrx = rd_f ? len : 4'd0;
      if (len > 4'(FCE_NB))             code = RC_BADLEN;
      else if (rd_f && wr_f)            code = RC_BOTH;
      else if (len != 0 && !rd_f && !wr_f) code = RC_NODIR;
    end
    launch = launch & we;
  end
endmodule

// File: rtl/fce_spi_seq.sv
module fce_spi_seq
  import fce_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  fce_cmd_t            cmd,
  output logic                busy,
  output logic                done,
  output logic [8*FCE_NB-1:0] rx,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  input  logic                miso
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic                run;
  logic [DIV_W-1:0]    div;
  logic [4:0]          bidx, last;
  logic [2:0]          bitn;
  logic [7:0]          sh, rsh, nxt;
  logic [3:0]          ntx;
  logic [8*FCE_NB-1:0] tx;
  logic [4:0]          rl5;
  logic [2:0]          rlane;

  assign busy  = run;
  assign rl5   = bidx - 5'(ntx) - 5'd1;
  assign rlane = rl5[2:0];
  assign nxt   = (bidx < 5'(ntx)) ? tx[{bidx[2:0], 3'b000} +: 8] : 8'h00;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      run <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0; mosi <= 1'b0;
      div <= '0; bidx <= '0; last <= '0; bitn <= '0;
      sh <= '0; rsh <= '0; ntx <= '0; tx <= '0; rx <= '0;
    end else if (!run) begin
      if (start) begin
        run  <= 1'b1;
        cs_n <= 1'b0;
        sclk <= 1'b0;
        div  <= '0;
        bidx <= '0;
        bitn <= 3'd7;
        sh   <= cmd.op;
        mosi <= cmd.op[7];
        ntx  <= cmd.ntx;
        tx   <= cmd.tx;
        last <= 5'(cmd.ntx) + 5'(cmd.nrx);
        rx   <= '0;
      end
    end else if (div != DIV_W'(CLK_DIV - 1)) begin
      div <= div + 1'b1;
    end else begin
      div <= '0;
      if (!sclk) begin
        sclk <= 1'b1;
        rsh  <= {rsh[6:0], miso};
      end else begin
        sclk <= 1'b0;
        if (bitn != 3'd0) begin
          bitn <= bitn - 1'b1;
          sh   <= {sh[6:0], 1'b0};
          mosi <= sh[6];
        end else begin
          if (bidx > 5'(ntx)) rx[{rlane, 3'b000} +: 8] <= rsh;
          if (bidx == last) begin
            run  <= 1'b0;
            cs_n <= 1'b1;
            mosi <= 1'b0;
            done <= 1'b1;
          end else begin
            bidx <= bidx + 1'b1;
            bitn <= 3'd7;
            sh   <= nxt;
            mosi <= nxt[7];
          end
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_waddr,
  input  logic [31:0]       reg_wdata,
  input  logic [ADDR_W-1:0] reg_raddr,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int PW = 8 * FCE_NB;

  logic [1:0]    mask_q;
  logic [7:0]    op_q;
  logic          rdf_q, wrf_q, err_q, rdv_q, rxcmd_q, irq_q;
  logic [3:0]    len_q;
  logic [PW-1:0] wd_q, rd_q, rx;
  logic [10:0]   resp_q, code;
  logic [31:0]   rdata_q;
  logic          launch, busy, done, start;
  fce_cmd_t      cmd;

  fce_cmd_build #(.ADDR_W(ADDR_W)) i_build (
    .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata), .len(len_q),
    .payload(wd_q), .launch(launch), .cmd(cmd), .code(code)
  );

  assign start = launch && !busy && (code == RC_OK);

  fce_spi_seq #(.CLK_DIV(CLK_DIV)) i_seq (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .busy(busy),
    .done(done), .rx(rx), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .miso(spi_miso)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= 2'b11; op_q <= '0; rdf_q <= 1'b0; wrf_q <= 1'b0;
      len_q <= '0; wd_q <= '0; rd_q <= '0; resp_q <= RC_OK;
      err_q <= 1'b0; rdv_q <= 1'b0; rxcmd_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      if (reg_we) begin
        if (reg_waddr == ADDR_W'(A_MASK)) mask_q <= reg_wdata[1:0];
        if (reg_waddr == ADDR_W'(A_LEN))  len_q  <= reg_wdata[3:0];
        if (reg_waddr == ADDR_W'(A_WLO))  wd_q[31:0]  <= reg_wdata;
        if (reg_waddr == ADDR_W'(A_WHI))  wd_q[63:32] <= reg_wdata;
        if (reg_waddr == ADDR_W'(A_CTRL)) begin
          op_q  <= reg_wdata[31:24];
          rdf_q <= reg_wdata[6];
          wrf_q <= reg_wdata[5];
        end
      end
      if (launch) begin
        if (busy) begin
          resp_q <= RC_BUSY;
          err_q  <= 1'b1;
        end else if (code != RC_OK) begin
          resp_q <= code;
          err_q  <= 1'b1;
        end else begin
          resp_q  <= RC_OK;
          rdv_q   <= 1'b0;
          rxcmd_q <= (cmd.nrx != 4'd0);
        end
      end
      if (done) begin
        rd_q <= rx;
        if (rxcmd_q) rdv_q <= 1'b1;
      end
      irq_q <= (err_q & mask_q[0]) | (rdv_q & mask_q[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (reg_raddr)
        ADDR_W'(A_RESP):  rdata_q <= {21'b0, resp_q};
        ADDR_W'(A_FLAGS): rdata_q <= {30'b0, rdv_q, err_q};
        ADDR_W'(A_MASK):  rdata_q <= {30'b0, mask_q};
        ADDR_W'(A_STRD):  rdata_q <= {24'b0, rd_q[7:0]};
        ADDR_W'(A_IDENT): rdata_q <= {rd_q[7:0], rd_q[15:8], rd_q[23:16], rd_q[31:24]};
        ADDR_W'(A_CTRL):  rdata_q <= {op_q, 17'b0, rdf_q, wrf_q, 5'b0};
        ADDR_W'(A_LEN):   rdata_q <= {28'b0, len_q};
        ADDR_W'(A_WLO):   rdata_q <= wd_q[31:0];
        ADDR_W'(A_WHI):   rdata_q <= wd_q[63:32];
        ADDR_W'(A_RLO):   rdata_q <= rd_q[31:0];
        ADDR_W'(A_RHI):   rdata_q <= rd_q[63:32];
        default:          rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/fce_checker.sv
module fce_checker (
  input logic        clk,
  input logic        rst,
  input logic        sclk,
  input logic        cs_n,
  input logic        mosi,
  input logic        irq,
  input logic        err,
  input logic        rdv,
  input logic [1:0]  mask,
  input logic [10:0] resp
);
  // R2
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R2
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $rose(sclk)) |-> $stable(mosi));

  // R6
  start_ok_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (resp == 11'd0));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  // R11
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (err && mask[0]) |=> irq);

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!(err && mask[0]) && !(rdv && mask[1])) |=> !irq);
endmodule

bind flash_cmd_engine fce_checker i_fce_checker (
  .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
  .irq(irq), .err(err_q), .rdv(rdv_q), .mask(mask_q), .resp(resp_q)
);

// File: tb/test_flash_cmd_engine.sv
module test_flash_cmd_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [4:0]  waddr = '0, raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, cs_n, sclk, mosi;
  logic        miso = 1'b0;

  int n_chk = 0, n_bad = 0, cycles = 0;
  int frames = 0, ncap = 0, inbits = 0, bitpos = 0;
  logic [7:0] cap [0:31];
  logic [7:0] shin = '0;
  logic [7:0] mseed = 8'h1C;

  flash_cmd_engine #(.ADDR_W(5), .CLK_DIV(2)) i_flash_cmd_engine (
    .clk(clk), .rst(rst), .reg_we(we), .reg_waddr(waddr), .reg_wdata(wdata),
    .reg_raddr(raddr), .reg_rdata(rdata), .irq(irq), .spi_cs_n(cs_n),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] sbyte(int i);
    return mseed + 8'(i * 29);
  endfunction

  function automatic logic mbit(int p);
    logic [7:0] b;
    b = sbyte(p / 8);
    return b[7 - (p % 8)];
  endfunction

  // flash model: MISO shifts on falling SCLK, MOSI captured on rising SCLK
  always @(negedge cs_n) begin bitpos = 0; ncap = 0; inbits = 0; miso = mbit(0); end
  always @(posedge sclk) if (!cs_n) begin
    shin = {shin[6:0], mosi};
    inbits++;
    if (inbits % 8 == 0 && ncap < 32) begin cap[ncap] = shin; ncap++; end
  end
  always @(negedge sclk) if (!cs_n) begin bitpos++; miso = mbit(bitpos); end
  always @(posedge cs_n) frames++;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(int a, logic [31:0] d);
    @(negedge clk); we = 1'b1; waddr = 5'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rreg(int a, output logic [31:0] d);
    @(negedge clk); raddr = 5'(a);
    @(negedge clk); d = rdata;
  endtask

  task automatic launch_wait(int a, logic [31:0] d);
    int f0;
    f0 = frames;
    wreg(a, d);
    wait (frames != f0);
    repeat (3) @(negedge clk);
  endtask

  // compare captured frame with an expected instruction plus payload
  task automatic chk_frame(string req, logic [7:0] op, int n, logic [63:0] pay);
    int bad;
    bad = -1;
    chk(ncap == n + 1, {req, " frame length"}, 64'(ncap), 64'(n + 1));
    if (cap[0] != op) bad = 0;
    for (int k = 0; k < n; k++) if (cap[k + 1] != pay[8*k +: 8] && bad < 0) bad = k + 1;
    chk(bad < 0, {req, " frame bytes"}, (bad < 0) ? 64'(0) : 64'(cap[bad]),
        (bad <= 0) ? 64'(op) : 64'(pay[8*(bad-1) +: 8]));
  endtask

  task automatic expect_reject(logic [31:0] ctl, logic [10:0] c, string req);
    int f0;
    logic [31:0] v;
    f0 = frames;
    wreg(8, ctl);
    repeat (4) @(negedge clk);
    chk(frames == f0, {req, " no transfer"}, 64'(frames - f0), 64'(0));
    rreg(0, v);
    chk(v == 32'(c), {req, " code"}, 64'(v), 64'(c));
    rreg(1, v);
    chk(v[0] == 1'b1, "R10 error flag set", 64'(v[0]), 64'(1));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v, v2;
    logic [63:0] pay, exp;
    logic [7:0] op;
    int n, f0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0 && irq == 1'b0, "R1 pins", {cs_n, sclk, irq}, 3'b100);
    rreg(0, v); chk(v == 0, "R1 result code", v, 0);
    rreg(1, v); chk(v == 0, "R1 flags", v, 0);
    rreg(2, v); chk(v == 3, "R1 mask", v, 3);

    // R2 R3 random writes plus directed lengths 0 and 8
    for (int t = 0; t < 12; t++) begin
      n = (t == 0) ? 8 : (t == 1) ? 0 : int'($urandom % 9);
      op = 8'($urandom);
      pay = {$urandom, $urandom};
      wreg(9, 32'(n)); wreg(10, pay[31:0]); wreg(11, pay[63:32]);
      launch_wait(8, {op, 24'h000021});
      chk_frame("R3 R2 write", op, n, pay);
      rreg(0, v); chk(v == 0, "R9 accepted code", v, 0);
    end

    // R5 control readback, launch bit reads 0
    rreg(8, v);
    chk(v[0] == 1'b0 && v[5] == 1'b1 && v[6] == 1'b0, "R5 control readback", v, {cap[0], 24'h000020});

    // R4 random reads, MOSI sends zeros, lanes beyond N read 0
    for (int t = 0; t < 10; t++) begin
      n = (t == 0) ? 8 : 1 + int'($urandom % 8);
      op = 8'($urandom);
      mseed = 8'($urandom);
      wreg(9, 32'(n));
      launch_wait(8, {op, 24'h000041});
      chk_frame("R4 read", op, n, 64'(0));
      exp = '0;
      for (int k = 0; k < n; k++) exp[8*k +: 8] = sbyte(k + 1);
      rreg(12, v); rreg(13, v2);
      chk({v2, v} == exp, "R4 result lanes", {v2, v}, exp);
      rreg(1, v); chk(v[1] == 1'b1, "R4 data ready", v, 2);
      chk(irq == 1'b1, "R11 irq from data ready", irq, 1);
    end

    // R11 mask off data-ready source
    wreg(2, 32'h1); repeat (2) @(negedge clk);
    chk(irq == 1'b0, "R11 masked irq", irq, 0);
    wreg(2, 32'h3); repeat (2) @(negedge clk);
    chk(irq == 1'b1, "R11 unmasked irq", irq, 1);

    // R7 zero length no flags: only the instruction; clears data ready (R4)
    wreg(9, 0);
    launch_wait(8, 32'h3C000001);
    chk_frame("R7 bare instruction", 8'h3C, 0, 64'(0));
    rreg(1, v); chk(v[1] == 1'b0, "R4 data ready cleared", v, 0);

    // R12 shortcuts
    launch_wait(3, 32'h1);
    chk_frame("R12 write enable", 8'h06, 0, 64'(0));
    launch_wait(4, 32'hAB);
    chk_frame("R12 status write", 8'h01, 1, 64'hAB);
    mseed = 8'h5A;
    launch_wait(5, 32'h0);
    chk_frame("R12 status read", 8'h05, 1, 64'(0));
    rreg(5, v); chk(v == {24'b0, sbyte(1)}, "R12 status byte", v, sbyte(1));

    // R13 erase and identification
    launch_wait(6, 32'h04FF0000);
    chk_frame("R13 erase", 8'hD8, 4, 64'h0000FF04);
    mseed = 8'h77;
    launch_wait(7, 32'h0);
    chk_frame("R13 ident", 8'h9F, 4, 64'(0));
    rreg(7, v);
    chk(v == {sbyte(1), sbyte(2), sbyte(3), sbyte(4)}, "R13 ident word", v,
        {sbyte(1), sbyte(2), sbyte(3), sbyte(4)});

    // error flag still clear before any rejection (R10)
    rreg(1, v); chk(v[0] == 1'b0, "R10 no error yet", v, 0);

    // R6 R7 R8 rejections
    wreg(9, 9);  expect_reject(32'h02000021, 11'd1, "R6 length 9");
    wreg(9, 15); expect_reject(32'h02000041, 11'd1, "R6 length 15");
    wreg(9, 3);  expect_reject(32'h02000001, 11'd2, "R7 no direction");
    wreg(9, 2);  expect_reject(32'h02000061, 11'd4, "R8 both flags");
    chk(irq == 1'b1, "R11 irq from error", irq, 1);

    // R9 busy: second launch during an 8-byte write
    pay = 64'h8877665544332211;
    wreg(9, 8); wreg(10, pay[31:0]); wreg(11, pay[63:32]);
    f0 = frames;
    wreg(8, 32'hA5000021);
    repeat (6) @(negedge clk);
    wreg(8, 32'h5A000021);
    rreg(0, v); chk(v == 3, "R9 busy code", v, 3);
    wait (frames != f0);
    repeat (40) @(negedge clk);
    chk(frames == f0 + 1, "R9 single frame", 64'(frames - f0), 1);
    chk_frame("R9 original frame", 8'hA5, 8, pay);

    // R10 sticky across a successful command
    launch_wait(3, 32'h1);
    rreg(0, v); chk(v == 0, "R10 later ok code", v, 0);
    rreg(1, v); chk(v[0] == 1'b1, "R10 error sticky", v, 1);

    // R1 R10 reset clears
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rreg(1, v); chk(v == 0, "R10 reset clears flags", v, 0);
    rreg(2, v); chk(v == 3, "R1 mask after reset", v, 3);
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule